// File: doc/BRIEF.md
# ADC Input Multiplexer Slot Sequencer

This block drives a single shared analog-to-digital converter through a repeating frame of time slots. In each slot it picks one analog signal, presents that signal's 4-bit code on the multiplexer select, and pulses a conversion start. It then waits for the filtered result. That result is written into a result RAM at an address fixed by the signal code, not by the slot position. The value is stored LSB-justified and moved up by eight bit positions. Slot boundaries are aligned to a slow reference clock. The system clock domain sees this clock as a single-cycle tick pulse. Each slot lasts one, two or three ticks, set by a filter-length setting.

Every slot has two select fields, a regular one and an alternate one. A one-cycle alternate request is held until the next frame starts. That frame then uses the alternate fields for every slot, which lets occasional channels such as temperature (code A) or battery voltage (code B) replace regular channels. The frame after it goes back to the regular fields. The number of active slots, the filter length and both select banks are sampled only when a frame starts. A result that misses its slot sets a sticky overrun flag. A synchronous enable holds the sequencer idle.

Top module: `adc_slot_seq`

## Requirements
- R1: After reset, mux_sel, cnv_start, ram_we, ram_addr, ram_wdata, frame_done and overrun are all zero.
- R2: While enable is low, the cycle that follows has no cnv_start, no ram_we and mux_sel equal to 0. After enable rises, the first frame starts on the next slow_tick.
- R3: A slot starts only on a clock edge at which slow_tick is high. cnv_start is high for exactly the one cycle after that edge. A slot lasts fir_len+1 ticks, and fir_len value 3 is treated as 2.
- R4: A frame has slot_count active slots, numbered 0 upward. A slot_count of 0 acts as 1, and a value above 10 acts as 10. After the last active slot the sequence wraps to slot 0.
- R5: Slot s takes its 4-bit code from bits [4s+3:4s] of the chosen select bank. mux_sel shows that code from the cnv_start cycle until the next slot starts.
- R6: An alt_req pulse is held until the next frame starts, whether enable is high or low. That frame takes every slot code from alt_sel. Later frames use reg_sel again.
- R7: The first cnv_valid seen in a running slot produces, one cycle later, ram_we=1 with ram_addr = BASE_ADDR (0x40) + code of the current slot and ram_wdata = cnv_data shifted left by 8. A cnv_valid that arrives after the slot already has a result, or while no frame is running, writes nothing.
- R8: If a slot ends with no cnv_valid accepted (counting one in the ending cycle), overrun goes high one cycle later and stays high until reset. An enable drop that aborts a slot does not set it.
- R9: frame_done pulses for one cycle, in the cycle after the tick that ends the last active slot. slot_count, fir_len, reg_sel and alt_sel are sampled only when a frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low holds the sequencer idle |
| slow_tick | input | 1 | One-cycle pulse marking a slow reference clock rising edge |
| slot_count | input | 4 | Number of active slots per frame |
| fir_len | input | 2 | Filter length setting; slot lasts fir_len+1 ticks |
| reg_sel | input | 40 | Regular select bank, 4 bits per slot |
| alt_sel | input | 40 | Alternate select bank, 4 bits per slot |
| alt_req | input | 1 | One-cycle request for an alternate frame |
| cnv_valid | input | 1 | Converter result valid pulse |
| cnv_data | input | 24 | Converter filtered result |
| mux_sel | output | 4 | Signal code of the current slot |
| cnv_start | output | 1 | Conversion start pulse |
| ram_we | output | 1 | Result RAM write enable |
| ram_addr | output | 8 | Result RAM write address |
| ram_wdata | output | 32 | Result RAM write data |
| frame_done | output | 1 | End-of-frame pulse |
| overrun | output | 1 | Sticky missed-result flag |

## Verification
The assertions take for granted that slow_tick is a single-cycle pulse and that there are several clock cycles between ticks. They also take for granted that cnv_valid is a one-cycle pulse. The bench's tick generator produces one tick every eight cycles. Its converter model answers each start with one valid pulse after a programmable delay. Spurious valid pulses are injected on purpose, so the bench also covers results that must be ignored. Configuration is changed in the middle of frames, and enable is dropped in the middle of a slot, to exercise the frame-boundary sampling and the abort path.

// File: rtl/adc_seq_pkg.sv
// Shared types and helpers for the ADC slot sequencer.
// Assumes 4-bit signal codes throughout.
package adc_seq_pkg;
    localparam int CODE_W = 4;
    typedef logic [CODE_W-1:0] sig_code_t;

    // Limit a requested slot count to the range 1..max_slots.
    function automatic int unsigned fit_slots(input int unsigned req, input int unsigned max_slots);
        if (req == 0)        return 1;
        if (req > max_slots) return max_slots;
        return req;
    endfunction

    // Limit the filter-length code to 0..2.
    function automatic logic [1:0] fit_len(input logic [1:0] len);
        return (len == 2'd3) ? 2'd2 : len;
    endfunction
endpackage

// File: rtl/adc_seq_timer.sv
// Slot timer: tracks the slot index and the tick count inside a slot,
// and flags slot and frame boundaries. The slot count and length are
// sampled at frame start. Assumes slow_tick is a one-cycle pulse.
module adc_seq_timer #(
    parameter int NSLOT = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             slow_tick,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [1:0]       cfg_len,
    output logic             running,
    output logic             frame_start,
    output logic             slot_start,
    output logic             slot_end,
    output logic             frame_end,
    output logic [CNT_W-1:0] next_idx
);
    import adc_seq_pkg::*;

    logic [CNT_W-1:0] cnt_q, idx_q;
    logic [1:0]       len_q, tick_q;
    logic             run_q;

    // Boundary detection from the current slot state.
    always_comb begin
        slot_end    = run_q && enable && slow_tick && (tick_q == len_q);
        frame_end   = slot_end && (idx_q == cnt_q - 1'b1);
        frame_start = enable && slow_tick && (!run_q || frame_end);
        slot_start  = frame_start || slot_end;
        next_idx    = frame_start ? '0 : idx_q + 1'b1;
        running     = run_q;
    end

    // Advance slot index and tick counter; load frame configuration.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_q  <= 1'b0;
            idx_q  <= '0;
            tick_q <= '0;
            if (!rst_n) begin
                cnt_q <= CNT_W'(1);
                len_q <= '0;
            end
        end else if (frame_start) begin
            run_q  <= 1'b1;
            idx_q  <= '0;
            tick_q <= '0;
            cnt_q  <= CNT_W'(fit_slots(int'(cfg_count), NSLOT));
            len_q  <= fit_len(cfg_len);
        end else if (slot_end) begin
            idx_q  <= idx_q + 1'b1;
            tick_q <= '0;
        end else if (run_q && slow_tick) begin
            tick_q <= tick_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_bank.sv
// Select bank: at frame start, copies either the regular or the
// alternate select fields into a frame-local bank. Gives the code for
// the slot about to start. Assumes next_idx < NSLOT when load is low.
module adc_seq_bank #(
    parameter int NSLOT = 10,
    parameter int CW    = 4,
    parameter int CNT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                use_alt,
    input  logic [NSLOT*CW-1:0] reg_flat,
    input  logic [NSLOT*CW-1:0] alt_flat,
    input  logic [CNT_W-1:0]    next_idx,
    output logic [CW-1:0]       sel_next
);
    logic [CW-1:0] pick_arr [NSLOT];
    logic [CW-1:0] bank_q   [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Choose the bank field for slot s.
        assign pick_arr[s] = use_alt ? alt_flat[s*CW +: CW] : reg_flat[s*CW +: CW];

        // Hold slot s's code for the whole frame.
        always_ff @(posedge clk) begin
            if (!rst_n)    bank_q[s] <= '0;
            else if (load) bank_q[s] <= pick_arr[s];
        end
    end

    // Code for the slot that starts at this edge.
    always_comb begin
        if (load)                         sel_next = pick_arr[0];
        else if (next_idx < CNT_W'(NSLOT)) sel_next = bank_q[next_idx];
        else                              sel_next = '0;
    end
endmodule

// File: rtl/adc_seq_writer.sv
// Result writer: takes the first converter result of each slot and
// writes it to a fixed per-signal RAM address, shifted left. Flags
// slots that end without a result. Assumes cnv_valid is a pulse.
module adc_seq_writer #(
    parameter int CW        = 4,
    parameter int RES_W     = 24,
    parameter int SHIFT     = 8,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 64,
    localparam int DATA_W   = RES_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              running,
    input  logic              cnv_valid,
    input  logic [RES_W-1:0]  cnv_data,
    input  logic [CW-1:0]     cur_sel,
    input  logic              slot_start,
    input  logic              slot_end,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              overrun
);
    logic got_q, accept;

    // A result counts only once per running slot.
    assign accept = enable && running && cnv_valid && !got_q;

    // Track whether the current slot already has its result.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) got_q <= 1'b0;
        else if (slot_start)   got_q <= 1'b0;
        else if (accept)       got_q <= 1'b1;
    end

    // Register the RAM write for an accepted result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= accept;
            if (accept) begin
                ram_addr  <= ADDR_W'(BASE_ADDR) + ADDR_W'(cur_sel);
                ram_wdata <= DATA_W'(cnv_data) << SHIFT;
            end
        end
    end

    // Sticky flag for a slot that closed without a result.
    always_ff @(posedge clk) begin
        if (!rst_n)                           overrun <= 1'b0;
        else if (slot_end && !got_q && !accept) overrun <= 1'b1;
    end
endmodule

// File: rtl/adc_slot_seq.sv
// ADC input multiplexer slot sequencer (top). Ties the slot timer, the
// select bank and the result writer together. Holds the alternate
// frame request and registers the mux select and the conversion start.
// Assumes slow_tick is a clk-domain pulse, one per slow clock rise.
module adc_slot_seq #(
    parameter int NSLOT     = 10,
    parameter int RES_W     = 24,
    parameter int SHIFT     = 8,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 64,
    localparam int CW       = adc_seq_pkg::CODE_W,
    localparam int CNT_W    = $clog2(NSLOT + 1),
    localparam int DATA_W   = RES_W + SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                slow_tick,
    input  logic [CNT_W-1:0]    slot_count,
    input  logic [1:0]          fir_len,
    input  logic [NSLOT*CW-1:0] reg_sel,
    input  logic [NSLOT*CW-1:0] alt_sel,
    input  logic                alt_req,
    input  logic                cnv_valid,
    input  logic [RES_W-1:0]    cnv_data,
    output logic [CW-1:0]       mux_sel,
    output logic                cnv_start,
    output logic                ram_we,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic                frame_done,
    output logic                overrun
);
    logic             running, frame_start, slot_start, slot_end, frame_end;
    logic [CNT_W-1:0] next_idx;
    logic [CW-1:0]    sel_next;
    logic             alt_pend, use_alt;

    assign use_alt = alt_pend || alt_req;

    adc_seq_timer #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .slow_tick(slow_tick),
        .cfg_count(slot_count), .cfg_len(fir_len), .running(running),
        .frame_start(frame_start), .slot_start(slot_start), .slot_end(slot_end),
        .frame_end(frame_end), .next_idx(next_idx)
    );

    adc_seq_bank #(.NSLOT(NSLOT), .CW(CW), .CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(frame_start), .use_alt(use_alt),
        .reg_flat(reg_sel), .alt_flat(alt_sel), .next_idx(next_idx),
        .sel_next(sel_next)
    );

    adc_seq_writer #(.CW(CW), .RES_W(RES_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W),
                     .BASE_ADDR(BASE_ADDR)) u_writer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .running(running),
        .cnv_valid(cnv_valid), .cnv_data(cnv_data), .cur_sel(mux_sel),
        .slot_start(slot_start), .slot_end(slot_end), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .overrun(overrun)
    );

    // Hold an alternate request until the next frame consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)           alt_pend <= 1'b0;
        else if (frame_start) alt_pend <= 1'b0;
        else if (alt_req)     alt_pend <= 1'b1;
    end

    // Register mux select, conversion start and frame-done outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            mux_sel    <= '0;
            cnv_start  <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            cnv_start  <= slot_start;
            frame_done <= frame_end;
            if (slot_start) mux_sel <= sel_next;
        end
    end
endmodule

// File: rtl/adc_seq_checker.sv
// Checker bound to the sequencer top. It only observes ports.
// Assumes slow_tick and cnv_valid are single-cycle pulses.
module adc_seq_checker #(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              slow_tick,
    input logic              cnv_valid,
    input logic [3:0]        mux_sel,
    input logic              cnv_start,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              frame_done,
    input logic              overrun
);
    // R3
    start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> $past(slow_tick) && $past(enable));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!cnv_start && !ram_we && mux_sel == 4'd0));

    // R7
    write_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(cnv_valid) && (ram_addr - ADDR_W'(BASE_ADDR) < ADDR_W'(16)));

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R9
    done_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> cnv_start);
endmodule

bind adc_slot_seq adc_seq_checker #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .slow_tick(slow_tick),
    .cnv_valid(cnv_valid), .mux_sel(mux_sel), .cnv_start(cnv_start),
    .ram_we(ram_we), .ram_addr(ram_addr), .frame_done(frame_done),
    .overrun(overrun)
);

// File: tb/test_adc_slot_seq.sv
// Bench: a behavioural reference model, compared on every clock.
module test_adc_slot_seq;
    localparam int BASE = 64;

    logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0, slow_tick = 1'b0;
    logic [3:0]  slot_count = 4'd7;
    logic [1:0]  fir_len = 2'd0;
    logic [39:0] reg_sel = '0, alt_sel = '0;
    logic        alt_req = 1'b0, cnv_valid = 1'b0;
    logic [23:0] cnv_data = '0;
    logic [3:0]  mux_sel;
    logic        cnv_start, ram_we, frame_done, overrun;
    logic [7:0]  ram_addr;
    logic [31:0] ram_wdata;

    int checks = 0, fails = 0;
    int conv_delay = 3, cd = 0, tcnt = 0;
    bit spurious = 0, done = 0;
    int n_writes = 0, n_alt_writes = 0, n_frames = 0;

    // reference model state
    int m_run = 0, m_slot = 0, m_tick = 0, m_cnt = 1, m_len = 0, m_got = 0;
    int m_alt_pend = 0, m_in_alt = 0;
    int m_bank [10];
    int e_mux = 0, e_start = 0, e_we = 0, e_addr = 0, e_done = 0, e_ovr = 0;
    longint e_data = 0;
    int e_en = 0;

    always #2.5 clk = ~clk;

    adc_slot_seq i_adc_slot_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .slow_tick(slow_tick),
        .slot_count(slot_count), .fir_len(fir_len), .reg_sel(reg_sel),
        .alt_sel(alt_sel), .alt_req(alt_req), .cnv_valid(cnv_valid),
        .cnv_data(cnv_data), .mux_sel(mux_sel), .cnv_start(cnv_start),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .frame_done(frame_done), .overrun(overrun)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: what the registered outputs must become at this edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_slot = 0; m_tick = 0; m_cnt = 1; m_len = 0; m_got = 0;
            m_alt_pend = 0; m_in_alt = 0;
            e_mux = 0; e_start = 0; e_we = 0; e_addr = 0; e_data = 0; e_done = 0; e_ovr = 0;
        end else begin
            int ncnt, nlen, alt_now;
            bit boundary, last, take;
            ncnt = (slot_count == 0) ? 1 : (slot_count > 10) ? 10 : int'(slot_count);
            nlen = (fir_len == 3) ? 2 : int'(fir_len);
            e_en = enable;
            e_start = 0; e_we = 0; e_done = 0;
            boundary = enable && slow_tick && m_run != 0 && m_tick == m_len;
            last = boundary && (m_slot == m_cnt - 1);
            take = enable && m_run != 0 && cnv_valid && m_got == 0;
            if (take) begin
                e_we = 1; e_addr = BASE + e_mux; e_data = longint'(cnv_data) * 256;
            end
            if (boundary && m_got == 0 && !take) e_ovr = 1;
            if (last) e_done = 1;
            alt_now = (m_alt_pend != 0 || alt_req) ? 1 : 0;
            if (!enable) begin
                m_run = 0; m_slot = 0; m_tick = 0; m_got = 0; e_mux = 0;
                m_alt_pend = alt_now;
            end else if (slow_tick && (m_run == 0 || last)) begin
                m_cnt = ncnt; m_len = nlen; m_in_alt = alt_now;
                for (int s = 0; s < 10; s++)
                    m_bank[s] = alt_now != 0 ? int'(alt_sel[s*4 +: 4]) : int'(reg_sel[s*4 +: 4]);
                m_alt_pend = 0; m_run = 1; m_slot = 0; m_tick = 0; m_got = 0;
                e_mux = m_bank[0]; e_start = 1;
            end else if (boundary) begin
                m_slot++; m_tick = 0; m_got = 0;
                e_mux = m_bank[m_slot]; e_start = 1; m_alt_pend = alt_now;
            end else begin
                if (take) m_got = 1;
                if (m_run != 0 && slow_tick) m_tick++;
                m_alt_pend = alt_now;
            end
        end
    end

    // Compare on every cycle, then drive the tick and the converter model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(e_en != 0 ? (m_in_alt != 0 ? "R6" : "R5 R4") : "R2", "mux_sel", mux_sel, e_mux);
            check(e_en != 0 ? "R3" : "R2", "cnv_start", cnv_start, e_start);
            check("R7", "ram_we", ram_we, e_we);
            if (e_we != 0) begin
                check("R7", "ram_addr", ram_addr, e_addr);
                check("R7", "ram_wdata", ram_wdata, e_data);
                n_writes++;
                if (ram_addr == 8'(BASE + 10) || ram_addr == 8'(BASE + 11)) n_alt_writes++;
            end
            check("R9", "frame_done", frame_done, e_done);
            if (e_done != 0) n_frames++;
            check("R8", "overrun", overrun, e_ovr);
        end
        tcnt++;
        slow_tick = (tcnt % 8 == 0);
        cnv_valid = 1'b0;
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin cnv_valid = 1'b1; cnv_data = 24'($urandom); end
        end
        if (cnv_start) cd = conv_delay;
        if (spurious && ($urandom % 11 == 0)) begin
            cnv_valid = 1'b1; cnv_data = 24'($urandom);
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        for (int s = 0; s < 10; s++) begin
            reg_sel[s*4 +: 4] = 4'(s);
            alt_sel[s*4 +: 4] = (s == 0) ? 4'hA : (s == 2) ? 4'hB : 4'(s);
        end
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(1);
        // R1: reset state at the ports
        check("R1", "reset mux_sel", mux_sel, 0);
        check("R1", "reset cnv_start", cnv_start, 0);
        check("R1", "reset ram_we", ram_we, 0);
        check("R1", "reset ram_addr", ram_addr, 0);
        check("R1", "reset ram_wdata", ram_wdata, 0);
        check("R1", "reset frame_done", frame_done, 0);
        check("R1", "reset overrun", overrun, 0);
        // R5 R7: seven slots, short filter
        enable = 1'b1; wait_cycles(400);
        // R9: mid-frame configuration change
        fir_len = 2'd1; slot_count = 4'd6; wait_cycles(500);
        // R6: alternate frame
        alt_req = 1'b1; wait_cycles(1); alt_req = 1'b0; wait_cycles(400);
        // R4: count clamps, R3: length 2 and code 3
        fir_len = 2'd2; slot_count = 4'd0; wait_cycles(200);
        fir_len = 2'd3; slot_count = 4'd15; wait_cycles(900);
        // R7: spurious valids ignored after a result
        spurious = 1; conv_delay = 5; fir_len = 2'd1; slot_count = 4'd7; wait_cycles(500);
        spurious = 0;
        // R2: enable drop in mid-frame, alternate request while idle
        enable = 1'b0; wait_cycles(10);
        alt_req = 1'b1; wait_cycles(1); alt_req = 1'b0; wait_cycles(26);
        enable = 1'b1; wait_cycles(400);
        check("R8", "overrun before late results", overrun, 0);
        // R8: results later than the slot
        fir_len = 2'd0; conv_delay = 12; wait_cycles(200);
        check("R8", "overrun sticky set", overrun, 1);
        check("R7", "writes seen", n_writes > 0, 1);
        check("R6", "alternate-code writes seen", n_alt_writes > 0, 1);
        check("R9", "frames completed", n_frames > 0, 1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end
endmodule